// File: doc/BRIEF.md
# Host Configuration Register Interface

This block sits between a host processor and the configuration engine of a programmable device. The host uses a small synchronous byte bus to stream configuration bytes into the engine. In readback mode it uses the same bus to pull configuration bytes back out, from a location that it sets in a 16-bit readback address. Four registers are decoded at fixed offsets:

| Offset | Register | Access |
|--------|----------|--------|
| 0 | Status | read-only |
| 1 | Data | write in configuration mode, read in readback mode |
| 2 | Readback address, low byte | write-only |
| 3 | Readback address, high byte | write-only |

The status register carries four kinds of information:

- A data-ready flag for the byte handshake.
- A sticky interrupt-pending flag.
- A latched two-bit bitstream error code.
- Live copies of the device's INIT and DONE levels.

Accesses have side effects on these bits. A data register access clears data-ready. A status read clears interrupt-pending. Only the program input clears the error code. An interrupt output combines the pending flag with the error code, and the error part is gated by an enable input.

Top module: `hcfg_regif`

## Requirements
- R1: A status read at offset 0 returns bit 0 and bit 5 as 0. A write to offset 0 changes no register.
- R2: A one-cycle `eng_strobe_i` pulse sets data-ready. Data-ready reads as status bit 1 from the next cycle on.
- R3: Any host read or write at offset 1 clears data-ready. If `eng_strobe_i` is high in the same cycle, the strobe wins and data-ready stays set.
- R4: Interrupt-pending (status bit 2) is set in the cycle after `user_irq_i` is high. A status read clears it only if `user_irq_i` is low in that cycle. The read data still shows the value from before the clear.
- R5: When `err_valid_i` is high and no error is held, a nonzero `err_code_i` is latched into status bits [4:3], with bit 3 as the LSB. The codes are 01 = ID, 10 = checksum, 11 = stop-bit/alignment. A held nonzero code ignores later error reports.
- R6: `prgm_i` high clears the error code to 00. This takes priority over an error report in the same cycle.
- R7: Status bit 6 equals `init_i` and bit 7 equals `done_i` in the same cycle, with no latching.
- R8: A write at offset 1 in configuration mode (`rb_mode_i` = 0) produces a one-cycle `cfg_valid_o` pulse in the next cycle, with the written byte on `cfg_byte_o`. The same write in readback mode produces no pulse.
- R9: A read at offset 1 in readback mode returns `rb_byte_i` in the same cycle, and `rb_take_o` pulses in the next cycle. In configuration mode the same read returns 0 and `rb_take_o` stays low.
- R10: Offset 2 writes `rb_addr_o[7:0]` and offset 3 writes `rb_addr_o[15:8]`. Each byte holds its value until it is written again. Reads at offsets 2 and 3 return 0.
- R11: `irq_o` is high while interrupt-pending is set, or while the error code is nonzero and `err_irq_en_i` is high.
- R12: After reset the status flags, the error code, `rb_addr_o`, `cfg_valid_o`, `rb_take_o` and `irq_o` are all 0. `rdata_o` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Host chip select |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, valid in the cycle of the read |
| rb_mode_i | input | 1 | 1 = readback mode, 0 = configuration mode |
| eng_strobe_i | input | 1 | Engine pulse: it can take a byte, or a readback byte is available |
| cfg_valid_o | output | 1 | Configuration byte offered to the engine |
| cfg_byte_o | output | 8 | Configuration byte |
| rb_byte_i | input | 8 | Readback byte from the engine |
| rb_take_o | output | 1 | Pulse: the host has consumed the readback byte |
| rb_addr_o | output | 16 | Readback location |
| err_valid_i | input | 1 | Error report strobe |
| err_code_i | input | 2 | Error code reported |
| err_irq_en_i | input | 1 | Let a held error drive the interrupt |
| prgm_i | input | 1 | Program input, active high; clears the error code |
| init_i | input | 1 | INIT level |
| done_i | input | 1 | DONE level |
| user_irq_i | input | 1 | Interrupt request from user logic |
| irq_o | output | 1 | Interrupt to the host |

## Verification
The assertions assume the host never raises `rd_i` and `wr_i` together. They also assume that every strobe and level input changes only between clock edges. If both strobes are high, the read wins, and the property for the lost write would not describe anything the host asked for. The bench drives all inputs on the falling edge and issues exactly one bus operation per two-cycle slot. It never overlaps a read with a write, so every input the properties see is stable across the rising edge.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;
  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_DATA = 1;
  localparam int unsigned OFF_RBA  = 2;

  localparam int unsigned STAT_RDY  = 1;
  localparam int unsigned STAT_PEND = 2;
  localparam int unsigned STAT_ERR  = 3;
  localparam int unsigned STAT_INIT = 6;
  localparam int unsigned STAT_DONE = 7;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_ID    = 2'b01,
    ERR_CSUM  = 2'b10,
    ERR_FRAME = 2'b11
  } err_code_e;
endpackage

// File: rtl/hcfg_status.sv
module hcfg_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       eng_strobe_i,
  input  logic       data_acc_i,
  input  logic       stat_rd_i,
  input  logic       user_irq_i,
  input  logic       err_valid_i,
  input  logic [1:0] err_code_i,
  input  logic       prgm_i,
  output logic       data_rdy_o,
  output logic       irq_pend_o,
  output logic [1:0] err_code_o
);
  import hcfg_pkg::*;

  logic      rdy_q, pend_q;
  err_code_e err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      // new engine event outranks the host clearing access
      if (eng_strobe_i)    rdy_q <= 1'b1;
      else if (data_acc_i) rdy_q <= 1'b0;

      if (user_irq_i)     pend_q <= 1'b1;
      else if (stat_rd_i) pend_q <= 1'b0;

      if (prgm_i)
        err_q <= ERR_NONE;
      else if (err_valid_i && err_code_i != 2'b00 && err_q == ERR_NONE)
        err_q <= err_code_e'(err_code_i);
    end
  end

  assign data_rdy_o = rdy_q;
  assign irq_pend_o = pend_q;
  assign err_code_o = err_q;

  assert_rdy_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_strobe_i |=> data_rdy_o);
  assert_rdy_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && !eng_strobe_i) |=> !data_rdy_o);
  assert_pend_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !user_irq_i) |=> !irq_pend_o);
  assert_err_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prgm_i && err_code_o != 2'b00) |=> $stable(err_code_o));
  assert_err_prgm_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prgm_i |=> (err_code_o == 2'b00));
endmodule

// File: rtl/hcfg_rb_addr.sv
module hcfg_rb_addr #(
  parameter int unsigned DW       = 8,
  parameter int unsigned RB_BYTES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [RB_BYTES-1:0]    wr_sel_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [RB_BYTES*DW-1:0] rb_addr_o
);
  for (genvar g = 0; g < RB_BYTES; g++) begin : g_byte
    logic [DW-1:0] byte_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         byte_q <= '0;
      else if (wr_sel_i[g]) byte_q <= wdata_i;
    end

    assign rb_addr_o[g*DW +: DW] = byte_q;

    assert_addr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_sel_i[g] |=> $stable(rb_addr_o[g*DW +: DW]));
    assert_addr_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_sel_i[g] |=> (rb_addr_o[g*DW +: DW] == $past(wdata_i)));
  end
endmodule

// File: rtl/hcfg_data_port.sv
module hcfg_data_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          rb_mode_i,
  input  logic [DW-1:0] wdata_i,
  output logic          cfg_valid_o,
  output logic [DW-1:0] cfg_byte_o,
  output logic          rb_take_o
);
  logic          valid_q, take_q;
  logic [DW-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      take_q  <= 1'b0;
      byte_q  <= '0;
    end else begin
      valid_q <= wr_i && !rb_mode_i;
      take_q  <= rd_i && rb_mode_i;
      if (wr_i && !rb_mode_i) byte_q <= wdata_i;
    end
  end

  assign cfg_valid_o = valid_q;
  assign cfg_byte_o  = byte_q;
  assign rb_take_o   = take_q;

  assert_cfg_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rb_mode_i) |=> (cfg_valid_o && cfg_byte_o == $past(wdata_i)));
  assert_cfg_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !rb_mode_i) |=> !cfg_valid_o);
  assert_rb_take_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rb_mode_i) |=> rb_take_o);
  assert_rb_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && rb_mode_i) |=> !rb_take_o);
endmodule

// File: rtl/hcfg_regif.sv
module hcfg_regif #(
  parameter int unsigned DW       = 8,
  parameter int unsigned RB_BYTES = 2,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  input  logic                   rb_mode_i,
  input  logic                   eng_strobe_i,
  output logic                   cfg_valid_o,
  output logic [DW-1:0]          cfg_byte_o,
  input  logic [DW-1:0]          rb_byte_i,
  output logic                   rb_take_o,
  output logic [RB_BYTES*DW-1:0] rb_addr_o,
  input  logic                   err_valid_i,
  input  logic [1:0]             err_code_i,
  input  logic                   err_irq_en_i,
  input  logic                   prgm_i,
  input  logic                   init_i,
  input  logic                   done_i,
  input  logic                   user_irq_i,
  output logic                   irq_o
);
  import hcfg_pkg::*;

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);

  logic rd_acc, wr_acc, hit_data, hit_stat;
  logic data_rdy, irq_pend;
  logic [1:0] err_code;
  logic [DW-1:0] stat_byte;
  logic [RB_BYTES-1:0] rba_sel;

  // read wins if both strobes are raised
  assign rd_acc   = cs_i && rd_i;
  assign wr_acc   = cs_i && wr_i && !rd_i;
  assign hit_data = (addr_i == A_DATA);
  assign hit_stat = (addr_i == A_STAT);

  for (genvar g = 0; g < RB_BYTES; g++) begin : g_rba_dec
    assign rba_sel[g] = wr_acc && (addr_i == ADDR_W'(OFF_RBA + g));
  end

  hcfg_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eng_strobe_i(eng_strobe_i),
    .data_acc_i  ((rd_acc || wr_acc) && hit_data),
    .stat_rd_i   (rd_acc && hit_stat),
    .user_irq_i  (user_irq_i),
    .err_valid_i (err_valid_i),
    .err_code_i  (err_code_i),
    .prgm_i      (prgm_i),
    .data_rdy_o  (data_rdy),
    .irq_pend_o  (irq_pend),
    .err_code_o  (err_code)
  );

  hcfg_rb_addr #(.DW(DW), .RB_BYTES(RB_BYTES)) u_rb_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (rba_sel),
    .wdata_i  (wdata_i),
    .rb_addr_o(rb_addr_o)
  );

  hcfg_data_port #(.DW(DW)) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_acc && hit_data),
    .rd_i       (rd_acc && hit_data),
    .rb_mode_i  (rb_mode_i),
    .wdata_i    (wdata_i),
    .cfg_valid_o(cfg_valid_o),
    .cfg_byte_o (cfg_byte_o),
    .rb_take_o  (rb_take_o)
  );

  always_comb begin
    stat_byte                          = '0;
    stat_byte[STAT_RDY]                = data_rdy;
    stat_byte[STAT_PEND]               = irq_pend;
    stat_byte[STAT_ERR +: 2]           = err_code;
    stat_byte[STAT_INIT]               = init_i;
    stat_byte[STAT_DONE]               = done_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      if (hit_stat)                    rdata_o = stat_byte;
      else if (hit_data && rb_mode_i)  rdata_o = rb_byte_i;
    end
  end

  assign irq_o = irq_pend || (err_code != 2'b00 && err_irq_en_i);

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && hit_stat) |-> (rdata_o[0] == 1'b0 && rdata_o[5] == 1'b0));
  assert_level_mirror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && hit_stat) |-> (rdata_o[7] == done_i && rdata_o[6] == init_i));
  assert_idle_rdata_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |-> (rdata_o == '0));
  assert_err_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_irq_en_i && err_code != 2'b00) |-> irq_o);
endmodule

// File: tb/hcfg_regif_bench.sv
module hcfg_regif_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        rb_mode_i = 1'b0, eng_strobe_i = 1'b0;
  logic        cfg_valid_o;
  logic [7:0]  cfg_byte_o;
  logic [7:0]  rb_byte_i = '0;
  logic        rb_take_o;
  logic [15:0] rb_addr_o;
  logic        err_valid_i = 1'b0;
  logic [1:0]  err_code_i = '0;
  logic        err_irq_en_i = 1'b0, prgm_i = 1'b0;
  logic        init_i = 1'b0, done_i = 1'b0, user_irq_i = 1'b0;
  logic        irq_o;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] rd_val;

  always #5 clk_i = ~clk_i;

  hcfg_regif u_hcfg_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rb_mode_i(rb_mode_i), .eng_strobe_i(eng_strobe_i),
    .cfg_valid_o(cfg_valid_o), .cfg_byte_o(cfg_byte_o),
    .rb_byte_i(rb_byte_i), .rb_take_o(rb_take_o), .rb_addr_o(rb_addr_o),
    .err_valid_i(err_valid_i), .err_code_i(err_code_i),
    .err_irq_en_i(err_irq_en_i), .prgm_i(prgm_i), .init_i(init_i),
    .done_i(done_i), .user_irq_i(user_irq_i), .irq_o(irq_o)
  );

  // [19:18] op (0 write, 1 read-compare, 2 address compare), [17:16] offset,
  // [15:8] write data or expected high address byte, [7:0] expected value
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 2'd2, 8'h34, 8'h00},
    {2'd0, 2'd3, 8'h12, 8'h00},
    {2'd2, 2'd0, 8'h12, 8'h34},
    {2'd1, 2'd2, 8'h00, 8'h00},
    {2'd1, 2'd3, 8'h00, 8'h00},
    {2'd0, 2'd2, 8'hA5, 8'h00},
    {2'd2, 2'd0, 8'h12, 8'hA5},
    {2'd0, 2'd0, 8'hFF, 8'h00},
    {2'd1, 2'd0, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    miscompares++;
    $display("FAIL R12 watchdog act=%h exp=%h", 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("R12 irq", {15'd0, irq_o}, 16'd0);
    check("R12 rb_addr", rb_addr_o, 16'd0);
    check("R12 cfg_valid/take", {14'd0, cfg_valid_o, rb_take_o}, 16'd0);
    check("R12 idle rdata", {8'd0, rdata_o}, 16'd0);
    rst_ni = 1'b1;
    bus_read(2'd0, rd_val);
    check("R12 status", {8'd0, rd_val}, 16'd0);

    // table walk: R10 address bytes, R1 status write ignored
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      case (v[19:18])
        2'd0: bus_write(v[17:16], v[15:8]);
        2'd1: begin
          bus_read(v[17:16], rd_val);
          check("R10/R1 read", {8'd0, rd_val}, {8'd0, v[7:0]});
        end
        default: check("R10 rb_addr", rb_addr_o, v[15:0]);
      endcase
    end

    // R7 live level mirrors
    init_i = 1'b1; done_i = 1'b1;
    bus_read(2'd0, rd_val);
    check("R7 init/done", {8'd0, rd_val}, 16'h00C0);
    init_i = 1'b0;
    bus_read(2'd0, rd_val);
    check("R7 done only", {8'd0, rd_val}, 16'h0080);
    done_i = 1'b0;

    // R2 / R3 data ready
    @(negedge clk_i); eng_strobe_i = 1'b1;
    @(negedge clk_i); eng_strobe_i = 1'b0;
    bus_read(2'd0, rd_val);
    check("R2 rdy set", {8'd0, rd_val}, 16'h0002);
    bus_read(2'd1, rd_val);
    check("R9 cfg-mode data read", {8'd0, rd_val}, 16'd0);
    check("R9 no take", {15'd0, rb_take_o}, 16'd0);
    bus_read(2'd0, rd_val);
    check("R3 rdy cleared by read", {8'd0, rd_val}, 16'd0);

    @(negedge clk_i); eng_strobe_i = 1'b1;
    @(negedge clk_i); eng_strobe_i = 1'b0;
    bus_write(2'd1, 8'h5A);
    check("R8 cfg push", {7'd0, cfg_valid_o, cfg_byte_o}, 16'h015A);
    @(negedge clk_i);
    check("R8 one-cycle pulse", {15'd0, cfg_valid_o}, 16'd0);
    bus_read(2'd0, rd_val);
    check("R3 rdy cleared by write", {8'd0, rd_val}, 16'd0);

    @(negedge clk_i);
    cs_i = 1'b1; wr_i = 1'b1; addr_i = 2'd1; wdata_i = 8'h11; eng_strobe_i = 1'b1;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0; eng_strobe_i = 1'b0;
    bus_read(2'd0, rd_val);
    check("R3 strobe wins", {8'd0, rd_val}, 16'h0002);
    bus_read(2'd1, rd_val);

    // R9 / R8 readback mode
    rb_mode_i = 1'b1; rb_byte_i = 8'hC3;
    bus_read(2'd1, rd_val);
    check("R9 rb data", {8'd0, rd_val}, 16'h00C3);
    check("R9 take pulse", {15'd0, rb_take_o}, 16'd1);
    bus_write(2'd1, 8'h77);
    check("R8 no push in readback", {15'd0, cfg_valid_o}, 16'd0);
    rb_mode_i = 1'b0;

    // R4 / R11 interrupt pending
    @(negedge clk_i); user_irq_i = 1'b1;
    @(negedge clk_i); user_irq_i = 1'b0;
    check("R11 irq from pending", {15'd0, irq_o}, 16'd1);
    bus_read(2'd0, rd_val);
    check("R4 pend set", {8'd0, rd_val}, 16'h0004);
    bus_read(2'd0, rd_val);
    check("R4 pend cleared", {8'd0, rd_val}, 16'd0);
    check("R11 irq low", {15'd0, irq_o}, 16'd0);
    @(negedge clk_i); user_irq_i = 1'b1;
    bus_read(2'd0, rd_val);
    bus_read(2'd0, rd_val);
    check("R4 source still high", {8'd0, rd_val}, 16'h0004);
    user_irq_i = 1'b0;
    bus_read(2'd0, rd_val);
    bus_read(2'd0, rd_val);
    check("R4 cleared after source drop", {8'd0, rd_val}, 16'd0);

    // R5 / R6 / R11 error code
    @(negedge clk_i); err_valid_i = 1'b1; err_code_i = 2'b10;
    @(negedge clk_i); err_valid_i = 1'b0;
    bus_read(2'd0, rd_val);
    check("R5 checksum code", {8'd0, rd_val}, 16'h0010);
    check("R11 err gated off", {15'd0, irq_o}, 16'd0);
    err_irq_en_i = 1'b1;
    #1 check("R11 err enabled", {15'd0, irq_o}, 16'd1);
    @(negedge clk_i); err_valid_i = 1'b1; err_code_i = 2'b11;
    @(negedge clk_i); err_valid_i = 1'b0;
    bus_read(2'd0, rd_val);
    check("R5 hold first code", {8'd0, rd_val}, 16'h0010);
    @(negedge clk_i); prgm_i = 1'b1;
    @(negedge clk_i); prgm_i = 1'b0;
    bus_read(2'd0, rd_val);
    check("R6 prgm clears", {8'd0, rd_val}, 16'd0);
    check("R11 irq after clear", {15'd0, irq_o}, 16'd0);
    @(negedge clk_i); prgm_i = 1'b1; err_valid_i = 1'b1; err_code_i = 2'b01;
    @(negedge clk_i); prgm_i = 1'b0; err_valid_i = 1'b0;
    bus_read(2'd0, rd_val);
    check("R6 prgm priority", {8'd0, rd_val}, 16'd0);
    @(negedge clk_i); err_valid_i = 1'b1;
    @(negedge clk_i); err_valid_i = 1'b0;
    bus_read(2'd0, rd_val);
    check("R5 id code bit3", {8'd0, rd_val}, 16'h0008);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule